// File: doc/BRIEF.md
# Four-Register Nonlinear Keystream Combiner

This block is the nonlinear output stage of a word-oriented stream generator. Each advance takes six 32-bit taps from two external shift registers. Two taps come from the first register (positions t and t+4). Four come from the second register (positions t, t+4, t+9 and t+10). The taps are combined with four internal 32-bit words, called R1, R2, L1 and L2, to form one 64-bit keystream word. In the same cycle the four words are refreshed through a word substitution step, so the two pairs of words form cross-coupled two-stage chains. The substitution step passes each byte of a word through the AES S-box and then mixes the four bytes with the AES column-mixing matrix.

The surrounding logic owns the shift registers, key loading and any feedback of keystream into them. Asserting `adv` for one cycle consumes the taps presented in that cycle. The keystream word computed from the state before the update appears on `ks_word` one cycle later, with `ks_valid` high. Asserting `clr` returns the internal words to zero. A two-state control machine tracks whether the output register was just loaded. `CTL_IDLE` moves to `CTL_EMIT` on the `step` transition (`adv` high, `clr` low). Every other input moves it back to `CTL_IDLE` (the `rest` transition). `ks_valid` is high exactly in `CTL_EMIT`.

Top module: `kc_core`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `ks_word` is zero and `ks_valid` is low. The internal words R1, R2, L1 and L2 are zero.
- R2: After an advance, `ks_word[63:32]` equals ((B[t+10] + L2) mod 2^32) XOR L1 XOR A[t]. The values used are the taps and the internal words of the advancing cycle.
- R3: After an advance, `ks_word[31:0]` equals ((B[t] + R2) mod 2^32) XOR R1 XOR A[t+4]. The values used are the taps and the internal words of the advancing cycle.
- R4: On an advance the internal words become R1 = Sub((L2 + B[t+9]) mod 2^32), R2 = Sub(R1), L1 = Sub((R2 + B[t+4]) mod 2^32) and L2 = Sub(L1). Every right-hand side uses the old values.
- R5: Sub replaces each byte of its word with the AES S-box value. That value is the multiplicative inverse modulo x^8+x^4+x^3+x+1, with 0 mapped to 0, followed by the AES affine transform with constant 0x63. For example, 0x00 maps to 0x63 and 0x53 maps to 0xED.
- R6: After substitution, Sub mixes the bytes c0 (bits 7:0) to c3 (bits 31:24) with the rows d0 = 2c0+3c1+c2+c3, d1 = c0+2c1+3c2+c3, d2 = c0+c1+2c2+3c3 and d3 = 3c0+c1+c2+2c3 over GF(2^8). Sub(0x00000053) is 0xEAEDED64.
- R7: A cycle with `adv` and `clr` both low leaves `ks_word` and the internal words unchanged, and `ks_valid` is low on the following cycle.
- R8: `ks_valid` is high in a cycle exactly when the previous cycle had `adv` high and `clr` low.
- R9: `clr` takes priority over `adv`. After a cycle with `clr` high, the internal words and `ks_word` are zero and `ks_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of internal words and output |
| adv | input | 1 | Advance strobe: consume taps, update state |
| tap_a0 | input | 32 | First shift register, position t |
| tap_a4 | input | 32 | First shift register, position t+4 |
| tap_b0 | input | 32 | Second shift register, position t |
| tap_b4 | input | 32 | Second shift register, position t+4 |
| tap_b9 | input | 32 | Second shift register, position t+9 |
| tap_b10 | input | 32 | Second shift register, position t+10 |
| ks_word | output | 64 | Keystream word, upper half bits 63:32 |
| ks_valid | output | 1 | High for one cycle after each advance |

## Verification
Directed sequences start from the cleared state with all taps zero. In that case the whole output depends on the constant Sub(0)=0x63636363, so an error in the zero-input S-box value or in the mixing constants shows up there. A single nonzero byte on the B[t+9] tap then reaches the lower half through R1, which exposes byte ordering and mixing row errors as a fixed word. Seeded random taps with a mostly-on advance strobe exercise the carries of the modular additions and the cross coupling of the two chains over long runs. Idle cycles and clears placed at random, including clears together with advance, separate the hold behaviour from the clear priority.

// File: rtl/kc_pkg.sv
package kc_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned LANES   = 4;
    localparam int unsigned WORD_W  = BYTE_W * LANES;
    localparam int unsigned KS_W    = 2 * WORD_W;
    localparam logic [7:0]  RED_LO  = 8'h1B;   // x^4+x^3+x+1 reduction term
    localparam logic [7:0]  AFF_C   = 8'h63;   // affine constant

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_EMIT = 1'b1
    } ctl_state_e;

    // multiply by x in GF(2^8)
    function automatic byte_t gf_dbl(input byte_t v);
        gf_dbl = {v[6:0], 1'b0} ^ (v[7] ? RED_LO : 8'h00);
    endfunction

    // general product in GF(2^8)
    function automatic byte_t gf_mul(input byte_t x, input byte_t y);
        byte_t acc;
        byte_t cur;
        acc = '0;
        cur = x;
        for (int i = 0; i < BYTE_W; i++) begin
            if (y[i]) acc = acc ^ cur;
            cur = gf_dbl(cur);
        end
        gf_mul = acc;
    endfunction

    // inverse as x^254; zero stays zero
    function automatic byte_t gf_inv(input byte_t x);
        byte_t pw;
        byte_t acc;
        pw  = x;
        acc = 8'h01;
        for (int i = 1; i < BYTE_W; i++) begin
            pw  = gf_mul(pw, pw);
            acc = gf_mul(acc, pw);
        end
        gf_inv = acc;
    endfunction

    function automatic byte_t aff(input byte_t x);
        byte_t r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = x[i] ^ x[(i+4)%BYTE_W] ^ x[(i+5)%BYTE_W]
                 ^ x[(i+6)%BYTE_W] ^ x[(i+7)%BYTE_W] ^ AFF_C[i];
        end
        aff = r;
    endfunction

endpackage

// File: rtl/kc_sbox.sv
module kc_sbox
    import kc_pkg::*;
(
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] dout
);
    logic [BYTE_W-1:0] inv_v;

    always_comb begin
        inv_v = gf_inv(din);
        dout  = aff(inv_v);
    end
endmodule

// File: rtl/kc_sub.sv
module kc_sub
    import kc_pkg::*;
(
    input  logic [WORD_W-1:0] win,
    output logic [WORD_W-1:0] wout
);
    logic [BYTE_W-1:0] sb [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        kc_sbox u_sb (
            .din  (win[g*BYTE_W +: BYTE_W]),
            .dout (sb[g])
        );
    end

    // circulant rows: lane g gets 2*c[g] ^ 3*c[g+1] ^ c[g+2] ^ c[g+3]
    for (genvar g = 0; g < LANES; g++) begin : g_mix
        always_comb begin
            wout[g*BYTE_W +: BYTE_W] =
                gf_dbl(sb[g])
              ^ gf_dbl(sb[(g+1)%LANES]) ^ sb[(g+1)%LANES]
              ^ sb[(g+2)%LANES]
              ^ sb[(g+3)%LANES];
        end
    end
endmodule

// File: rtl/kc_mixout.sv
module kc_mixout
    import kc_pkg::*;
(
    input  logic [WORD_W-1:0] add_tap,
    input  logic [WORD_W-1:0] add_reg,
    input  logic [WORD_W-1:0] xor_reg,
    input  logic [WORD_W-1:0] xor_tap,
    output logic [WORD_W-1:0] half
);
    logic [WORD_W-1:0] sum_v;

    always_comb begin
        sum_v = add_tap + add_reg;
        half  = sum_v ^ xor_reg ^ xor_tap;
    end
endmodule

// File: rtl/kc_core.sv
module kc_core
    import kc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [31:0]       tap_a0,
    input  logic [31:0]       tap_a4,
    input  logic [31:0]       tap_b0,
    input  logic [31:0]       tap_b4,
    input  logic [31:0]       tap_b9,
    input  logic [31:0]       tap_b10,
    output logic [63:0]       ks_word,
    output logic              ks_valid
);
    localparam int unsigned NREG = 4;

    ctl_state_e ctl_q, ctl_d;

    logic [WORD_W-1:0] r1_q, r2_q, l1_q, l2_q;
    logic [WORD_W-1:0] sub_in  [NREG];
    logic [WORD_W-1:0] sub_out [NREG];
    logic [WORD_W-1:0] z_hi, z_lo;
    logic [KS_W-1:0]   ks_q;
    logic              step;

    assign step = adv & ~clr;

    // substitution inputs: 0->R1, 1->R2, 2->L1, 3->L2
    always_comb begin
        sub_in[0] = l2_q + tap_b9;
        sub_in[1] = r1_q;
        sub_in[2] = r2_q + tap_b4;
        sub_in[3] = l1_q;
    end

    for (genvar g = 0; g < NREG; g++) begin : g_sub
        kc_sub u_sub (
            .win  (sub_in[g]),
            .wout (sub_out[g])
        );
    end

    kc_mixout u_hi (
        .add_tap (tap_b10),
        .add_reg (l2_q),
        .xor_reg (l1_q),
        .xor_tap (tap_a0),
        .half    (z_hi)
    );

    kc_mixout u_lo (
        .add_tap (tap_b0),
        .add_reg (r2_q),
        .xor_reg (r1_q),
        .xor_tap (tap_a4),
        .half    (z_lo)
    );

    // control state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_IDLE;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        ctl_d = CTL_IDLE;
        unique case (ctl_q)
            CTL_IDLE: ctl_d = step ? CTL_EMIT : CTL_IDLE;
            CTL_EMIT: ctl_d = step ? CTL_EMIT : CTL_IDLE;
            default:  ctl_d = CTL_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r1_q <= '0;
            r2_q <= '0;
            l1_q <= '0;
            l2_q <= '0;
            ks_q <= '0;
        end else if (clr) begin
            r1_q <= '0;
            r2_q <= '0;
            l1_q <= '0;
            l2_q <= '0;
            ks_q <= '0;
        end else if (adv) begin
            r1_q <= sub_out[0];
            r2_q <= sub_out[1];
            l1_q <= sub_out[2];
            l2_q <= sub_out[3];
            ks_q <= {z_hi, z_lo};
        end
    end

    // outputs
    always_comb begin
        ks_word  = ks_q;
        ks_valid = (ctl_q == CTL_EMIT);
    end
endmodule

// File: rtl/kc_chk.sv
module kc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clr,
    input logic        adv,
    input logic [31:0] tap_a0,
    input logic [31:0] tap_b10,
    input logic [31:0] r1_q,
    input logic [31:0] r2_q,
    input logic [31:0] l1_q,
    input logic [31:0] l2_q,
    input logic [63:0] ks_word,
    input logic        ks_valid
);
    // R1
    reset_zero_chk: assert property (@(posedge clk)
        !rst_n |=> (ks_word == '0 && !ks_valid && r1_q == '0 && l2_q == '0));

    // R8
    valid_after_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> ks_valid);

    // R8
    valid_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv && !clr) |=> !ks_valid);

    // R7
    hold_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> ($stable(ks_word) && $stable(r1_q) && $stable(r2_q)
                            && $stable(l1_q) && $stable(l2_q)));

    // R9
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ks_word == '0 && r1_q == '0 && r2_q == '0
                 && l1_q == '0 && l2_q == '0));

    // R2
    upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=>
            ks_word[63:32] == $past((tap_b10 + l2_q) ^ l1_q ^ tap_a0));
endmodule

bind kc_core kc_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .adv      (adv),
    .tap_a0   (tap_a0),
    .tap_b10  (tap_b10),
    .r1_q     (r1_q),
    .r2_q     (r2_q),
    .l1_q     (l1_q),
    .l2_q     (l2_q),
    .ks_word  (ks_word),
    .ks_valid (ks_valid)
);

// File: tb/sim_kc_core.sv
module sim_kc_core;
    localparam int CLK_PER  = 10;
    localparam int N_RAND   = 400;
    localparam int WD_LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst_n, clr, adv;
    logic [31:0] a0, a4, b0, b4, b9, b10;
    logic [63:0] ks_word;
    logic        ks_valid;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [31:0] m_r1, m_r2, m_l1, m_l2;
    logic [63:0] e_z;
    logic        e_v;

    always #(CLK_PER/2) clk = ~clk;

    kc_core u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .adv(adv),
        .tap_a0(a0), .tap_a4(a4), .tap_b0(b0), .tap_b4(b4),
        .tap_b9(b9), .tap_b10(b10), .ks_word(ks_word), .ks_valid(ks_valid)
    );

    // ---------------- reference model ----------------
    function automatic logic [7:0] rf_mul(input logic [7:0] x, input logic [7:0] y);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (y[i]) p = p ^ (16'(x) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h011B << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] rf_sbox(input logic [7:0] x);
        logic [7:0] iv;
        logic [7:0] r;
        iv = 8'h00;
        for (int k = 1; k < 256; k++)
            if (x != 0 && rf_mul(x, 8'(k)) == 8'h01) iv = 8'(k);
        r = iv ^ {iv[6:0], iv[7]} ^ {iv[5:0], iv[7:6]}
               ^ {iv[4:0], iv[7:5]} ^ {iv[3:0], iv[7:4]} ^ 8'h63;
        return r;
    endfunction

    function automatic logic [31:0] rf_mix(input logic [31:0] c);
        logic [7:0] b [4];
        logic [31:0] d;
        for (int i = 0; i < 4; i++) b[i] = c[i*8 +: 8];
        d[7:0]   = rf_mul(b[0], 2) ^ rf_mul(b[1], 3) ^ b[2] ^ b[3];
        d[15:8]  = b[0] ^ rf_mul(b[1], 2) ^ rf_mul(b[2], 3) ^ b[3];
        d[23:16] = b[0] ^ b[1] ^ rf_mul(b[2], 2) ^ rf_mul(b[3], 3);
        d[31:24] = rf_mul(b[0], 3) ^ b[1] ^ b[2] ^ rf_mul(b[3], 2);
        return d;
    endfunction

    function automatic logic [31:0] rf_sub(input logic [31:0] w);
        logic [31:0] s;
        for (int i = 0; i < 4; i++) s[i*8 +: 8] = rf_sbox(w[i*8 +: 8]);
        return rf_mix(s);
    endfunction

    // ---------------- checking ----------------
    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive one cycle at a falling edge, check at the next falling edge
    task automatic step(input logic s_adv, input logic s_clr,
                        input logic [31:0] x_a0, input logic [31:0] x_a4,
                        input logic [31:0] x_b0, input logic [31:0] x_b4,
                        input logic [31:0] x_b9, input logic [31:0] x_b10);
        logic [31:0] n1, n2, n3, n4;
        adv = s_adv; clr = s_clr;
        a0 = x_a0; a4 = x_a4; b0 = x_b0; b4 = x_b4; b9 = x_b9; b10 = x_b10;
        if (s_clr) begin
            m_r1 = '0; m_r2 = '0; m_l1 = '0; m_l2 = '0;
            e_z = '0; e_v = 1'b0;
        end else if (s_adv) begin
            e_z = {((x_b10 + m_l2) ^ m_l1 ^ x_a0), ((x_b0 + m_r2) ^ m_r1 ^ x_a4)};
            e_v = 1'b1;
            n1 = rf_sub(m_l2 + x_b9);
            n2 = rf_sub(m_r1);
            n3 = rf_sub(m_r2 + x_b4);
            n4 = rf_sub(m_l1);
            m_r1 = n1; m_r2 = n2; m_l1 = n3; m_l2 = n4;
        end else begin
            e_v = 1'b0;
        end
        @(negedge clk);
        chk("R2 R4 upper half", {32'h0, ks_word[63:32]}, {32'h0, e_z[63:32]});
        chk("R3 R4 lower half", {32'h0, ks_word[31:0]},  {32'h0, e_z[31:0]});
        if (s_clr)       chk("R9 valid after clear", {63'h0, ks_valid}, 64'h0);
        else if (!s_adv) chk("R7 valid after idle",  {63'h0, ks_valid}, 64'h0);
        else             chk("R8 valid after step",  {63'h0, ks_valid}, {63'h0, e_v});
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WD_LIMIT) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; clr = 1'b0; adv = 1'b0;
        a0 = '0; a4 = '0; b0 = '0; b4 = '0; b9 = '0; b10 = '0;
        m_r1 = '0; m_r2 = '0; m_l1 = '0; m_l2 = '0; e_z = '0; e_v = 1'b0;

        // bench model against known constants
        chk("R5 sbox(00)", {56'h0, rf_sbox(8'h00)}, 64'h63);
        chk("R5 sbox(53)", {56'h0, rf_sbox(8'h53)}, 64'hED);
        chk("R6 mix known", {32'h0, rf_mix(32'h455313DB)}, 64'hBCA14D8E);

        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 word in reset", ks_word, 64'h0);
        chk("R1 valid in reset", {63'h0, ks_valid}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 word after reset", ks_word, 64'h0);
        chk("R1 valid after reset", {63'h0, ks_valid}, 64'h0);

        // directed: zero taps from zero state give zero output
        step(1'b1, 1'b0, 0, 0, 0, 0, 32'h00000053, 0);
        chk("R2 zero state", ks_word, 64'h0);
        // R1 = Sub(0x53), R2 = Sub(0) now
        step(1'b1, 1'b0, 0, 0, 0, 0, 0, 0);
        chk("R5 R6 sub through lower half", {32'h0, ks_word[31:0]},
            {32'h0, 32'h63636363 ^ 32'hEAEDED64});
        chk("R4 upper half after zero step", {32'h0, ks_word[63:32]}, 64'h0);

        // R7: idle with changing taps holds output
        held = ks_word;
        step(1'b0, 1'b0, 32'hFFFFFFFF, 32'h12345678, 32'hDEADBEEF, 32'h1, 32'h2, 32'h3);
        chk("R7 output held", ks_word, held);
        step(1'b1, 1'b0, 32'h1, 32'h2, 32'hFFFFFFFF, 32'h4, 32'h5, 32'hFFFFFFFF);

        // R9: clear with advance
        step(1'b1, 1'b1, 32'hA5A5A5A5, 32'h5A5A5A5A, 32'h1, 32'h1, 32'h1, 32'h1);
        chk("R9 clear zero word", ks_word, 64'h0);
        step(1'b1, 1'b0, 0, 0, 0, 0, 0, 0);
        chk("R9 state zero after clear", ks_word, 64'h0);

        // random run
        for (int i = 0; i < N_RAND; i++) begin
            logic r_adv, r_clr;
            r_adv = ($urandom % 4) != 0;
            r_clr = ($urandom % 32) == 0;
            step(r_adv, r_clr, $urandom, $urandom, $urandom,
                 $urandom, $urandom, $urandom);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule